// File: doc/BRIEF.md
# RGMII Transmit Clock Generator

This block derives the RGMII transmit clock for an external PHY. It runs on one working clock and counts tick strobes from one of two parent sources, so every rate in the chain is an exact whole number of working-clock cycles. A single control word selects the parent, sets a divider that counts from one, gates the output and picks a transmit delay tap. A fixed halving stage always follows the divider. System software programs the word once for the gigabit rate. After that, the generator follows a line-speed input by itself: it slows the output by 1, 5 or 50 without any further writes.

Each toggle of the output comes after N × K selected parent ticks. N is the divider value, with zero treated as one. K is the speed factor. A full output period is therefore 2 × N × K ticks. Changes to the divider, the parent select, the speed and the gate are held back and applied only when the output is low and its next rising edge is due. This means no shortened pulse can appear. The delayed copy of the clock trails the output by 0 to 3 working-clock taps.

Top module: `rgtx_txclk_gen`

## Requirements
- R1: After reset, the control word reads back as zero, and both `txc_out` and `txc_dly` are low.
- R2: A write stores the gate bit at position 10, the divider at bits 9:7, the delay tap at bits 6:5 and the parent select at bit 4. The readback from the cycle after the write shows exactly those bits, and every other bit reads 0.
- R3: With the gate on, each high phase and each low phase lasts N × K selected ticks, where N is the divider field. A field value of 0 acts as 1.
- R4: Speed code 00 gives K = 50, code 01 gives K = 5, and codes 10 and 11 both give K = 1.
- R5: Parent select 0 counts `par_tick_a`, and parent select 1 counts `par_tick_b`.
- R6: While the applied gate bit is 0, `txc_out` and `txc_dly` stay low.
- R7: A configuration or speed change that arrives while the output is high does not shorten the high phase. The new settings take effect at the next rising edge.
- R8: `txc_dly` equals `txc_out` delayed by D working-clock cycles, where D is the delay field (0 to 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Working clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word readback |
| par_tick_a | input | 1 | Tick strobe of parent source 0 |
| par_tick_b | input | 1 | Tick strobe of parent source 1 |
| line_speed | input | 2 | 00 = 10 Mbit/s, 01 = 100 Mbit/s, 1x = 1 Gbit/s |
| txc_out | output | 1 | Transmit clock |
| txc_dly | output | 1 | Transmit clock after the selected delay taps |

## Verification
The bench builds the block with its default speed factors of 50, 5 and 1. With these values the slowest half period, a divider of 7 at 10 Mbit/s, is 350 cycles when ticks come every cycle and 700 cycles on the alternating second parent. A full sweep of divider, speed and parent therefore fits in a short run, and every half period can be counted exactly. The factor of 1 on the gigabit setting makes the divider alone visible. This lets the zero-as-one case, the mid-pulse reconfiguration and each delay tap be measured against half periods of only a few cycles.

// File: rtl/rgtx_pkg.sv
package rgtx_pkg;
  localparam int CFG_W   = 16;
  localparam int SEL_BIT = 4;
  localparam int DLY_LSB = 5;
  localparam int DLY_W   = 2;
  localparam int DIV_LSB = 7;
  localparam int DIV_W   = 3;
  localparam int EN_BIT  = 10;

  typedef enum logic [1:0] {
    SPD_10M    = 2'b00,
    SPD_100M   = 2'b01,
    SPD_1G     = 2'b10,
    SPD_1G_ALT = 2'b11
  } line_speed_e;

  typedef struct packed {
    logic             en;
    logic [DIV_W-1:0] div;
    logic [DLY_W-1:0] dly;
    logic             sel;
  } txclk_cfg_t;
endpackage

// File: rtl/rgtx_cfg_reg.sv
module rgtx_cfg_reg
  import rgtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output txclk_cfg_t       cfg,
  output logic [CFG_W-1:0] rdata
);
  txclk_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr) begin
      cfg_d.en  = wdata[EN_BIT];
      cfg_d.div = wdata[DIV_LSB +: DIV_W];
      cfg_d.dly = wdata[DLY_LSB +: DLY_W];
      cfg_d.sel = wdata[SEL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    rdata                     = '0;
    rdata[EN_BIT]             = cfg_q.en;
    rdata[DIV_LSB +: DIV_W]   = cfg_q.div;
    rdata[DLY_LSB +: DLY_W]   = cfg_q.dly;
    rdata[SEL_BIT]            = cfg_q.sel;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/rgtx_div_chain.sv
module rgtx_div_chain
  import rgtx_pkg::*;
#(
  parameter int SLOW_MUL = 50,
  parameter int FAST_MUL = 5,
  parameter int GIG_MUL  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_a,
  input  logic             tick_b,
  input  logic             sh_en,
  input  logic [DIV_W-1:0] sh_div,
  input  logic             sh_sel,
  input  logic [1:0]       sh_spd,
  output logic             txc,
  output logic             act_en,
  output logic [DIV_W-1:0] act_div,
  output logic             act_sel,
  output logic [1:0]       act_spd
);
  localparam int MAX_AB  = (SLOW_MUL > FAST_MUL) ? SLOW_MUL : FAST_MUL;
  localparam int MUL_MAX = (MAX_AB > GIG_MUL) ? MAX_AB : GIG_MUL;
  localparam int SPD_W   = $clog2(MUL_MAX + 1);

  logic             act_en_q, act_en_d;
  logic [DIV_W-1:0] act_div_q, act_div_d;
  logic             act_sel_q, act_sel_d;
  logic [1:0]       act_spd_q, act_spd_d;
  logic [DIV_W-1:0] div_cnt_q, div_cnt_d;
  logic [SPD_W-1:0] spd_cnt_q, spd_cnt_d;
  logic             txc_q, txc_d;

  logic             sel_tick, div_last, spd_last, pre_tick, tgl, commit;
  logic [DIV_W-1:0] n_lim;
  logic [SPD_W-1:0] k_lim;

  always_comb begin
    case (line_speed_e'(act_spd_q))
      SPD_10M:  k_lim = SPD_W'(SLOW_MUL);
      SPD_100M: k_lim = SPD_W'(FAST_MUL);
      default:  k_lim = SPD_W'(GIG_MUL);
    endcase
  end

  always_comb begin
    sel_tick = act_sel_q ? tick_b : tick_a;
    n_lim    = (act_div_q == '0) ? DIV_W'(1) : act_div_q;
    div_last = (div_cnt_q == n_lim - DIV_W'(1));
    spd_last = (spd_cnt_q == k_lim - SPD_W'(1));
    pre_tick = act_en_q & sel_tick & div_last;
    tgl      = pre_tick & spd_last;
    commit   = ~txc_q & (tgl | ~act_en_q);

    act_en_d  = act_en_q;
    act_div_d = act_div_q;
    act_sel_d = act_sel_q;
    act_spd_d = act_spd_q;
    div_cnt_d = div_cnt_q;
    spd_cnt_d = spd_cnt_q;
    txc_d     = txc_q;

    if (act_en_q && sel_tick) div_cnt_d = div_last ? '0 : div_cnt_q + DIV_W'(1);
    if (pre_tick)             spd_cnt_d = spd_last ? '0 : spd_cnt_q + SPD_W'(1);
    if (tgl)                  txc_d     = ~txc_q;

    if (commit) begin
      act_en_d  = sh_en;
      act_div_d = sh_div;
      act_sel_d = sh_sel;
      act_spd_d = sh_spd;
      div_cnt_d = '0;
      spd_cnt_d = '0;
      txc_d     = tgl & sh_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en_q  <= 1'b0;
      act_div_q <= '0;
      act_sel_q <= 1'b0;
      act_spd_q <= '0;
      div_cnt_q <= '0;
      spd_cnt_q <= '0;
      txc_q     <= 1'b0;
    end else begin
      act_en_q  <= act_en_d;
      act_div_q <= act_div_d;
      act_sel_q <= act_sel_d;
      act_spd_q <= act_spd_d;
      div_cnt_q <= div_cnt_d;
      spd_cnt_q <= spd_cnt_d;
      txc_q     <= txc_d;
    end
  end

  assign txc     = txc_q;
  assign act_en  = act_en_q;
  assign act_div = act_div_q;
  assign act_sel = act_sel_q;
  assign act_spd = act_spd_q;
endmodule

// File: rtl/rgtx_phase_tap.sv
module rgtx_phase_tap #(
  parameter int TAPS  = 4,
  localparam int SEL_W = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);
  logic [TAPS-1:0] line;

  assign line[0] = din;

  for (genvar i = 1; i < TAPS; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line[i] <= 1'b0;
      else        line[i] <= line[i-1];
    end
  end

  assign dout = line[sel];
endmodule

// File: rtl/rgtx_txclk_gen.sv
module rgtx_txclk_gen
  import rgtx_pkg::*;
#(
  parameter int SLOW_MUL = 50,
  parameter int FAST_MUL = 5,
  parameter int GIG_MUL  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             par_tick_a,
  input  logic             par_tick_b,
  input  logic [1:0]       line_speed,
  output logic             txc_out,
  output logic             txc_dly
);
  localparam int TAPS = 1 << DLY_W;

  txclk_cfg_t       cfg;
  logic [DLY_W-1:0] dly_sel;
  logic             act_en, act_sel;
  logic [DIV_W-1:0] act_div;
  logic [1:0]       act_spd;

  rgtx_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  rgtx_div_chain #(
    .SLOW_MUL (SLOW_MUL),
    .FAST_MUL (FAST_MUL),
    .GIG_MUL  (GIG_MUL)
  ) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_a  (par_tick_a),
    .tick_b  (par_tick_b),
    .sh_en   (cfg.en),
    .sh_div  (cfg.div),
    .sh_sel  (cfg.sel),
    .sh_spd  (line_speed),
    .txc     (txc_out),
    .act_en  (act_en),
    .act_div (act_div),
    .act_sel (act_sel),
    .act_spd (act_spd)
  );

  assign dly_sel = cfg.dly;

  rgtx_phase_tap #(.TAPS(TAPS)) u_tap (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (txc_out),
    .sel   (dly_sel),
    .dout  (txc_dly)
  );
endmodule

// File: rtl/rgtx_chk.sv
module rgtx_chk
  import rgtx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             txc_out,
  input logic             txc_dly,
  input logic [DLY_W-1:0] dly_sel,
  input logic             act_en,
  input logic [DIV_W-1:0] act_div,
  input logic             act_sel,
  input logic [1:0]       act_spd
);
  localparam logic [CFG_W-1:0] FIELD_MASK = 16'h07F0;

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata == ($past(cfg_wdata) & FIELD_MASK));

  a_r6_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |-> !txc_out);

  a_r7_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    txc_out |=> $stable({act_en, act_div, act_sel, act_spd}));

  a_r8_tap0: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_sel == 2'd0) |-> (txc_dly == txc_out));

  a_r8_tap1: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_sel == 2'd1) |-> (txc_dly == $past(txc_out, 1)));

  a_r8_tap2: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_sel == 2'd2) |-> (txc_dly == $past(txc_out, 2)));

  a_r8_tap3: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_sel == 2'd3) |-> (txc_dly == $past(txc_out, 3)));
endmodule

bind rgtx_txclk_gen rgtx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .txc_out   (txc_out),
  .txc_dly   (txc_dly),
  .dly_sel   (dly_sel),
  .act_en    (act_en),
  .act_div   (act_div),
  .act_sel   (act_sel),
  .act_spd   (act_spd)
);

// File: tb/rgtx_txclk_gen_tb.sv
module rgtx_txclk_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        par_tick_a, par_tick_b;
  logic [1:0]  line_speed;
  logic        txc_out, txc_dly;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rgtx_txclk_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .par_tick_a (par_tick_a),
    .par_tick_b (par_tick_b),
    .line_speed (line_speed),
    .txc_out    (txc_out),
    .txc_dly    (txc_dly)
  );

  function automatic logic [15:0] mk(input bit en, input int div, input int dly, input bit sel);
    logic [15:0] w;
    w = '0;
    w[10]  = en;
    w[9:7] = div[2:0];
    w[6:5] = dly[1:0];
    w[4]   = sel;
    return w;
  endfunction

  function automatic int n_of(input int div);
    return (div == 0) ? 1 : div;
  endfunction

  function automatic int k_of(input int spd);
    return (spd == 0) ? 50 : (spd == 1) ? 5 : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] w);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic measure(output int hi, output int lo);
    int g;
    hi = -1; lo = -1;
    g = 0;
    while (txc_out && g < 5000) begin @(negedge clk); g++; end
    while (!txc_out && g < 10000) begin @(negedge clk); g++; end
    if (g >= 10000) return;
    hi = 0;
    while (txc_out && hi < 5000) begin hi++; @(negedge clk); end
    lo = 0;
    while (!txc_out && lo < 5000) begin lo++; @(negedge clk); end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // Parent source B ticks every other cycle.
  initial begin
    par_tick_b = 1'b0;
    forever begin
      @(negedge clk);
      par_tick_b = ~par_tick_b;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  task automatic run_case(input int div, input int spd, input bit sel, input string req);
    int hi, lo, exp;
    line_speed = spd[1:0];
    wr(mk(1'b1, div, 0, sel));
    measure(hi, lo);
    measure(hi, lo);
    exp = n_of(div) * k_of(spd) * (sel ? 2 : 1);
    chk(hi == exp, req, hi, exp);
    chk(lo == exp, req, lo, exp);
  endtask

  initial begin
    int hi, lo, cnt, off;
    logic [15:0] w;
    void'($urandom(32'h1A2B));
    rst_n = 1'b0;
    cfg_wr = 1'b0;
    cfg_wdata = '0;
    par_tick_a = 1'b1;
    line_speed = 2'b10;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cfg_rdata == 16'h0, "R1 rdata", cfg_rdata, 0);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (txc_out || txc_dly) cnt++;
    end
    chk(cnt == 0, "R1 outputs low", cnt, 0);

    // R2 field placement and masking (gate kept off)
    for (int i = 0; i < 4; i++) begin
      w = 16'($urandom()) & 16'hFBFF;
      wr(w);
      chk(cfg_rdata == (w & 16'h07F0), "R2 readback", cfg_rdata, w & 16'h07F0);
    end
    wr(16'hFBFF);
    chk(cfg_rdata == 16'h03F0, "R2 all ones", cfg_rdata, 16'h03F0);
    wr(16'h0000);

    // R3 divider counts from one, zero acts as one
    run_case(0, 2, 1'b0, "R3 div0");
    run_case(1, 2, 1'b0, "R3 div1");
    run_case(7, 2, 1'b0, "R3 div7");

    // R4 speed scaling
    run_case(2, 0, 1'b0, "R4 10M");
    run_case(2, 1, 1'b0, "R4 100M");
    run_case(2, 3, 1'b0, "R4 code11");

    // R5 parent select
    run_case(3, 2, 1'b1, "R5 parent B");
    run_case(3, 2, 1'b0, "R5 parent A");

    // R8 delay taps
    line_speed = 2'b10;
    for (int d = 0; d < 4; d++) begin
      wr(mk(1'b1, 4, d, 1'b0));
      measure(hi, lo);
      while (txc_out) @(negedge clk);
      while (!txc_out) @(negedge clk);
      off = 0;
      while (!txc_dly && off < 10) begin off++; @(negedge clk); end
      chk(off == d, "R8 tap offset", off, d);
    end

    // R7 change during high phase is deferred
    wr(mk(1'b1, 4, 0, 1'b0));
    measure(hi, lo);
    while (txc_out) @(negedge clk);
    while (!txc_out) @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = mk(1'b1, 1, 0, 1'b0);
    hi = 1;
    @(negedge clk);
    cfg_wr = 1'b0;
    while (txc_out && hi < 100) begin hi++; @(negedge clk); end
    chk(hi == 4, "R7 high kept", hi, 4);
    measure(hi, lo);
    chk(hi == 1, "R7 new setting applied", hi, 1);

    // R6 gate off keeps output flat
    wr(mk(1'b0, 2, 1, 1'b0));
    repeat (50) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (txc_out || txc_dly) cnt++;
    end
    chk(cnt == 0, "R6 gate off", cnt, 0);

    // Random sweep (R3 R4 R5)
    for (int i = 0; i < 8; i++) begin
      int div, spd;
      bit sel;
      div = int'($urandom_range(0, 7));
      spd = int'($urandom_range(0, 3));
      sel = 1'($urandom_range(0, 1));
      run_case(div, spd, sel, "R3 R4 R5 random");
    end

    done = 1;
    finish_up();
  end
endmodule